// File: doc/BRIEF.md
# Dual-Width Memory Read Front End

This block sits between a chip's read-control pins and a 256K x 16 storage array that answers with one cycle of read latency. It takes an active-low chip select, an active-low output gate and a width strap. It also takes a shared pin that carries the top data bit when the port is 16 bits wide and acts as an extra, lowest address bit when the port is 8 bits wide. From these it produces a 16-bit data bus with three drive enables: the low lane (bits 7:0), the middle lane (bits 14:8) and the top bit (bit 15).

When a flag reports an over-voltage on one address line, the block replaces the array word with a fixed identification word. Address bit 0 chooses between the maker code and the part code. The identification request is honoured only when every address bit other than bit 0 and the flagged line is low. Otherwise the block performs an ordinary array read and latches an error flag. The control inputs are registered on the same clock edge as the array address, so the gating and the returned data always belong to the same sample.

Top module: `dwrd_front`

## Requirements
- R1: While `sel_n` is sampled high, the next cycle has all three enables low and `dq_out` equal to zero, whatever `gate_n`, `wide`, `lsb_pin` and `hv_flag` are.
- R2: While `sel_n` is sampled low and `gate_n` is sampled high, the next cycle has all three enables low and `dq_out` equal to zero.
- R3: `arr_addr` equals `addr` in the same cycle. The outputs in cycle N+1 depend only on the inputs sampled at the edge ending cycle N, together with `arr_rdata` as it stands in cycle N+1.
- R4: In word mode (`wide` = 1), with select and gate both low, all three enables are high and `dq_out` carries the full 16-bit word, where bit 15 is word bit 15.
- R5: In byte mode (`wide` = 0), `en_mid` and `en_top` stay low and `dq_out[15:8]` is zero in every cycle.
- R6: In byte mode with the bus active, `lsb_pin` = 1 puts word bits 15:8 on `dq_out[7:0]`, and `lsb_pin` = 0 puts word bits 7:0 there.
- R7: When `hv_flag` = 1 and every address bit except bits 0 and 9 is 0, the word is the maker code 16'h00C2 if `addr[0]` = 0 and the part code 16'h3800 if `addr[0]` = 1. The value of `addr[9]` does not matter.
- R8: Bit 15 of each identification word is computed so that the 16-bit word has an odd number of ones.
- R9: In byte mode, an identification read puts the low byte of the code on `dq_out[7:0]` (8'hC2 for the maker code, 8'h00 for the part code), whatever the value of `lsb_pin`.
- R10: When `hv_flag` = 1 while some address bit other than bits 0 and 9 is 1, the block returns the array word as in a normal read. If `sel_n` was low, it also sets `id_addr_err` in the next cycle.
- R11: `id_addr_err` stays set until reset. A bad identification request made while `sel_n` is high does not set it.
- R12: After a synchronous active-low reset, all enables are low, `dq_out` is zero and `id_addr_err` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| gate_n | input | 1 | Output gate, active low |
| wide | input | 1 | Width strap: 1 = 16-bit, 0 = 8-bit |
| lsb_pin | input | 1 | Extra lowest address bit in byte mode |
| hv_flag | input | 1 | Over-voltage detected on address bit 9 |
| addr | input | 18 | Word address |
| arr_addr | output | 18 | Address to the array read port |
| arr_rdata | input | 16 | Array word, valid one cycle after the address |
| dq_out | output | 16 | Data bus value, zero where not enabled |
| en_lo | output | 1 | Drive enable, bits 7:0 |
| en_mid | output | 1 | Drive enable, bits 14:8 |
| en_top | output | 1 | Drive enable, bit 15 |
| id_addr_err | output | 1 | Sticky flag for a malformed identification request |

## Verification
The bench sweeps every combination of select, gate, strap and extra address bit over several array words. A design that let the gate override a high select, or that enabled the top bit in byte mode, would drive a bus it should have released. It also probes the byte lane swap, where a crossed mux would return the wrong half of the word. Identification requests are sent with bit 9 set and with stray address bits set. A design that decoded bit 9 as part of the address, or that honoured a dirty request, would return a code where array data belongs. The sticky flag is exercised with select high, across later clean reads, and through reset.

// File: rtl/dwrd_pkg.sv
// Package: shared types and helpers for the dual-width read front end.
// Assumes a 16-bit array word split into an 8-bit low lane and an upper half.
package dwrd_pkg;
    localparam int WORD_W = 16;
    localparam int LANE_W = WORD_W / 2;

    // Control state captured with the array address.
    typedef struct packed {
        logic active;   // select and gate both asserted
        logic wide;     // 16-bit mode
        logic take_hi;  // byte mode: route upper half to low lane
        logic use_id;   // clean identification request
        logic id_part;  // identification: part code instead of maker code
    } rd_ctrl_t;

    // Build an identification word with odd parity in the top bit.
    function automatic logic [WORD_W-1:0] odd_word(input logic [WORD_W-2:0] body);
        return {~(^body), body};
    endfunction
endpackage

// File: rtl/dwrd_decode.sv
// Module: registers the read controls alongside the array address and checks
// identification requests. Assumes the flagged line's logic value is meaningless.
module dwrd_decode
    import dwrd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int HV_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              gate_n,
    input  logic              wide,
    input  logic              lsb_pin,
    input  logic              hv_flag,
    input  logic [ADDR_W-1:0] addr,
    output rd_ctrl_t          ctrl_q,
    output logic              id_err
);
    logic [ADDR_W-1:0] stray;
    logic              clean;

    // Purpose: isolate address bits that must be low for an ID read.
    always_comb begin
        stray         = addr;
        stray[0]      = 1'b0;
        stray[HV_BIT] = 1'b0;
        clean         = ~|stray;
    end

    // Purpose: capture the controls in the same cycle as the array access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q.active  <= !sel_n && !gate_n;
            ctrl_q.wide    <= wide;
            ctrl_q.take_hi <= lsb_pin;
            ctrl_q.use_id  <= hv_flag && clean;
            ctrl_q.id_part <= addr[0];
        end
    end

    // Purpose: sticky flag for an ID request with stray address bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_err <= 1'b0;
        else if (!sel_n && hv_flag && !clean)
            id_err <= 1'b1;
    end

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(id_err) |-> id_err);
endmodule

// File: rtl/dwrd_steer.sv
// Module: selects array or identification word and steers it onto the lanes.
// Assumes the control struct and the array word refer to the same sample.
module dwrd_steer
    import dwrd_pkg::*;
#(
    parameter logic [WORD_W-2:0] MAKER_BODY = 15'h00C2,
    parameter logic [WORD_W-2:0] PART_BODY  = 15'h3800
) (
    input  rd_ctrl_t          ctrl,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic [WORD_W-1:0] dq_out,
    output logic              en_lo,
    output logic              en_mid,
    output logic              en_top
);
    localparam logic [WORD_W-1:0] MAKER_W = odd_word(MAKER_BODY);
    localparam logic [WORD_W-1:0] PART_W  = odd_word(PART_BODY);

    logic [WORD_W-1:0] word;
    logic [LANE_W-1:0] low_lane;
    logic              swap;

    // Purpose: choose the source word.
    always_comb begin
        if (ctrl.use_id)
            word = ctrl.id_part ? PART_W : MAKER_W;
        else
            word = arr_rdata;
        swap = !ctrl.wide && ctrl.take_hi && !ctrl.use_id;
    end

    // One mux per bit of the low lane.
    for (genvar i = 0; i < LANE_W; i++) begin : g_lane
        assign low_lane[i] = swap ? word[i + LANE_W] : word[i];
    end

    // Purpose: apply gating and width to the bus and the enables.
    always_comb begin
        en_lo  = ctrl.active;
        en_mid = ctrl.active && ctrl.wide;
        en_top = ctrl.active && ctrl.wide;
        if (!ctrl.active)
            dq_out = '0;
        else if (ctrl.wide)
            dq_out = word;
        else
            dq_out = {{LANE_W{1'b0}}, low_lane};
    end
endmodule

// File: rtl/dwrd_front.sv
// Module: top of the dual-width read front end. Passes the address to a
// synchronous array and gates the returned word one cycle later.
// Assumes the array answers exactly one clock after the address.
module dwrd_front
    import dwrd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int HV_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              gate_n,
    input  logic              wide,
    input  logic              lsb_pin,
    input  logic              hv_flag,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic [WORD_W-1:0] dq_out,
    output logic              en_lo,
    output logic              en_mid,
    output logic              en_top,
    output logic              id_addr_err
);
    rd_ctrl_t ctrl_q;

    assign arr_addr = addr;

    dwrd_decode #(.ADDR_W(ADDR_W), .HV_BIT(HV_BIT)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .gate_n(gate_n),
        .wide(wide), .lsb_pin(lsb_pin), .hv_flag(hv_flag), .addr(addr),
        .ctrl_q(ctrl_q), .id_err(id_addr_err)
    );

    dwrd_steer u_steer (
        .ctrl(ctrl_q), .arr_rdata(arr_rdata), .dq_out(dq_out),
        .en_lo(en_lo), .en_mid(en_mid), .en_top(en_top)
    );

    // R1
    desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sel_n) |-> !en_lo && !en_mid && !en_top);
    // R2
    gate_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!sel_n && gate_n) |-> !en_lo && !en_mid && !en_top);
    // R4
    word_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!sel_n && !gate_n && wide) |-> en_lo && en_mid && en_top);
    // R5
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!wide) |-> !en_mid && !en_top && dq_out[15:8] == 8'h00);
endmodule

// File: tb/sim_dwrd_front.sv
`timescale 1ns/1ps
module sim_dwrd_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, gate_n = 1'b1, wide = 1'b1, lsb_pin = 1'b0, hv_flag = 1'b0;
    logic [17:0] addr = '0;
    logic [17:0] arr_addr;
    logic [15:0] arr_rdata;
    logic [15:0] dq_out;
    logic        en_lo, en_mid, en_top, id_addr_err;
    int          checks = 0, failures = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    dwrd_front u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .gate_n(gate_n), .wide(wide),
        .lsb_pin(lsb_pin), .hv_flag(hv_flag), .addr(addr), .arr_addr(arr_addr),
        .arr_rdata(arr_rdata), .dq_out(dq_out), .en_lo(en_lo), .en_mid(en_mid),
        .en_top(en_top), .id_addr_err(id_addr_err)
    );

    function automatic logic [15:0] mem_word(input logic [17:0] a);
        logic [31:0] t;
        t = 32'(a) * 32'd40503;
        return t[15:0] ^ 16'(a >> 2) ^ 16'hC35A;
    endfunction

    // Synchronous array model, one cycle of latency.
    always @(posedge clk) arr_rdata <= mem_word(arr_addr);

    function automatic logic [18:0] expect_out(input logic s, input logic g, input logic w,
                                               input logic p, input logic h, input logic [17:0] a);
        logic        act, idok;
        logic [15:0] wd, d;
        act  = !s && !g;
        idok = h && ((a & ~18'h00201) == 18'h0);
        wd   = idok ? (a[0] ? 16'h3800 : 16'h00C2) : mem_word(a);
        if (!act)   return 19'h0;
        if (w)      return {3'b111, wd};
        d = {8'h00, (p && !idok) ? wd[15:8] : wd[7:0]};
        return {3'b100, d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic s, input logic g, input logic w,
                        input logic p, input logic h, input logic [17:0] a);
        sel_n = s; gate_n = g; wide = w; lsb_pin = p; hv_flag = h; addr = a;
        #0;
        chk("R3 addr pass", 32'(arr_addr), 32'(a));
        @(posedge clk);
        @(negedge clk);
        chk(req, 32'({en_lo, en_mid, en_top, dq_out}), 32'(expect_out(s, g, w, p, h, a)));
    endtask

    initial begin
        logic [17:0] alist [4];
        alist[0] = 18'h00000; alist[1] = 18'h3FFFF; alist[2] = 18'h12345; alist[3] = 18'h2A5C3;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset", 32'({en_lo, en_mid, en_top, dq_out, id_addr_err}), 32'h0);
        rst_n = 1'b1;
        // R1 R2 R4 R5 R6 full control sweep
        for (int k = 0; k < 4; k++)
            for (int c = 0; c < 16; c++)
                step(c[3] ? "R1 R2 R4 R5 R6 sweep" : "R4 R5 R6 sweep",
                     c[3], c[2], c[1], c[0], 1'b0, alist[k]);
        // R7 R8 identification in word mode; bit 9 ignored
        step("R7 R8 maker", 0, 0, 1, 0, 1, 18'h00000);
        step("R7 R8 part", 0, 0, 1, 0, 1, 18'h00001);
        step("R7 bit9 maker", 0, 0, 1, 1, 1, 18'h00200);
        step("R7 bit9 part", 0, 0, 1, 0, 1, 18'h00201);
        // R9 identification in byte mode, both lsb_pin values
        for (int c = 0; c < 4; c++)
            step("R9 byte id", 0, 0, 0, c[1], 1, {17'h0, c[0]});
        // R1 identification hidden when deselected
        step("R1 id deselect", 1, 0, 1, 0, 1, 18'h00000);
        chk("R11 no flag yet", 32'(id_addr_err), 32'h0);
        // R11 bad request while deselected does not set flag
        step("R11 desel bad", 1, 0, 1, 0, 1, 18'h00002);
        chk("R11 desel no flag", 32'(id_addr_err), 32'h0);
        // R10 bad request reads the array and sets the flag
        step("R10 bad id word", 0, 0, 1, 0, 1, 18'h00400);
        chk("R10 flag set", 32'(id_addr_err), 32'h1);
        step("R10 bad id byte", 0, 0, 0, 1, 1, 18'h20001);
        // R11 flag persists across clean reads
        step("R11 clean read", 0, 0, 1, 0, 0, 18'h00777);
        step("R11 clean id", 0, 0, 1, 0, 1, 18'h00001);
        chk("R11 flag held", 32'(id_addr_err), 32'h1);
        // R12 reset clears flag
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R12 reset clears", 32'({en_lo, en_mid, en_top, dq_out, id_addr_err}), 32'h0);
        rst_n = 1'b1;
        step("R4 after reset", 0, 0, 1, 0, 0, 18'h0BEEF);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule